// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block turns FIFO fill levels, a device interrupt line and two error events into interrupt-request flags and a single interrupt output. It compares the read-FIFO occupancy against a programmable read threshold, the write-FIFO occupancy against a programmable write threshold, and reports whether the read FIFO holds data and whether the write FIFO has room. The device interrupt, a transfer-terminate error and a bus-timeout error are caught in sticky flags. Software clears a sticky flag by writing a one to its bit.

Both thresholds and all flags share one 32-bit status/threshold register. A write strobe loads the threshold fields and clears sticky flags in the same access. Seven enable bits, one per flag, come from a control register outside this block. The interrupt output is the registered OR of every enabled flag.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is held, `reg_rdata` reads 0x0018_0008: read threshold 8 in bits [9:0], write threshold 24 (depth 32 minus 8) in bits [25:16], and every flag clear. `irq` is 0.
- R2: A cycle with `reg_wr` high loads bits [9:0] of `reg_wdata` as the read threshold and bits [25:16] as the write threshold. The new values read back from the next cycle.
- R3: A read threshold written above 8 is stored as 8. Values of 8 or less are stored unchanged.
- R4: Bit 10 (read almost full) is 1 when the read occupancy is greater than or equal to the read threshold. It reflects the levels and threshold from one clock earlier.
- R5: Bit 11 (read not empty) is 1 when the read occupancy is nonzero, with one clock of latency.
- R6: Bit 12 (write almost empty) is 1 when the write occupancy is less than or equal to the write threshold, with one clock of latency.
- R7: Bit 13 (write not full) is 1 when the write occupancy is below the depth of 32, with one clock of latency.
- R8: Bit 15 (device interrupt), bit 28 (terminated transfer) and bit 29 (bus timeout) set one clock after their input is high. They stay set until a register write carries a one in that bit. Writing a zero leaves them unchanged. A set condition in the same cycle as a clear wins.
- R9: `irq` is 1 exactly one clock after any flag is 1 while its enable is 1. Enable index mapping: 0 read almost full, 1 read not empty, 2 write almost empty, 3 write not full, 4 device interrupt, 5 terminated transfer, 6 bus timeout.
- R10: Bits 14, 26, 27, 30 and 31 always read zero, and writing ones to them has no effect on any readable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_level | input | CNT_W (6) | Read-FIFO occupancy in words |
| wr_level | input | CNT_W (6) | Write-FIFO occupancy in words |
| dev_irq | input | 1 | Device interrupt line, level |
| term_err | input | 1 | Transfer-terminate error event |
| bus_tmo | input | 1 | Bus-timeout error event |
| irq_en | input | 7 | Per-flag enable bits, mapping as in R9 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| irq | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed latency, counted from the clock edge that first samples the stimulus:

| Stimulus | Result | Latency |
|----------|--------|---------|
| Threshold write, sticky clear | Register contents | One edge |
| Level change, sticky event | Flag | One edge |
| Flag change, enable change | `irq` | One further edge |

Level-to-interrupt therefore takes two edges. The bench drives inputs just after a falling edge and checks them at later falling edges, counting exactly that many rising edges. On the first of the two edges it also checks that `irq` has not yet changed.

// File: rtl/fifo_irq_pkg.sv
// Package: fifo_irq_pkg
// Shared bit positions, source indices and flag type for the FIFO threshold
// interrupt controller. Bit positions are fixed because software decodes them.
package fifo_irq_pkg;

    // Register field positions
    localparam int RD_THR_LSB = 0;
    localparam int WR_THR_LSB = 16;
    localparam int THR_W      = 10;
    localparam int REG_W      = 32;

    localparam int BIT_RD_AF  = 10;
    localparam int BIT_RD_NE  = 11;
    localparam int BIT_WR_AE  = 12;
    localparam int BIT_WR_NF  = 13;
    localparam int BIT_DEV    = 15;
    localparam int BIT_TERM   = 28;
    localparam int BIT_TMO    = 29;

    // Number of interrupt sources (width of the enable vector)
    localparam int N_SRC      = 7;
    // Number of sticky sources
    localparam int N_STICKY   = 3;

    // Flag vector; bit 0 is the read-almost-full source, matching enable index
    typedef struct packed {
        logic tmo;
        logic term;
        logic dev;
        logic wr_nf;
        logic wr_ae;
        logic rd_ne;
        logic rd_af;
    } irq_flags_t;

endpackage

// File: rtl/fifo_irq_thresh.sv
// Module: fifo_irq_thresh
// Holds the read and write thresholds. The read threshold is clamped to
// RD_THR_MAX on write. Assumes the write strobe is a single-cycle qualifier.
module fifo_irq_thresh #(
    parameter int THR_W      = 10,
    parameter int RD_THR_MAX = 8,
    parameter int WR_THR_RST = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [THR_W-1:0] rd_thr_in,
    input  logic [THR_W-1:0] wr_thr_in,
    output logic [THR_W-1:0] rd_thr,
    output logic [THR_W-1:0] wr_thr
);

    localparam logic [THR_W-1:0] RD_MAX_V = THR_W'(RD_THR_MAX);
    localparam logic [THR_W-1:0] WR_RST_V = THR_W'(WR_THR_RST);

    logic [THR_W-1:0] rd_thr_clamped;

    // Saturate the requested read threshold at the supported maximum
    always_comb begin
        rd_thr_clamped = (rd_thr_in > RD_MAX_V) ? RD_MAX_V : rd_thr_in;
    end

    // Threshold storage with reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_thr <= RD_MAX_V;
            wr_thr <= WR_RST_V;
        end else if (wr_en) begin
            rd_thr <= rd_thr_clamped;
            wr_thr <= wr_thr_in;
        end
    end

endmodule

// File: rtl/fifo_irq_level.sv
// Module: fifo_irq_level
// Registers the four FIFO-level flags from the current occupancy counts and
// thresholds. Flags follow the level with one clock of latency.
// Assumes THR_W >= CNT_W so counts extend losslessly to threshold width.
module fifo_irq_level #(
    parameter int CNT_W      = 6,
    parameter int THR_W      = 10,
    parameter int FIFO_DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rd_level,
    input  logic [CNT_W-1:0] wr_level,
    input  logic [THR_W-1:0] rd_thr,
    input  logic [THR_W-1:0] wr_thr,
    output logic             rd_af,
    output logic             rd_ne,
    output logic             wr_ae,
    output logic             wr_nf
);

    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(FIFO_DEPTH);

    logic [THR_W-1:0] rd_ext;
    logic [THR_W-1:0] wr_ext;

    // Widen the counts to threshold width for comparison
    always_comb begin
        rd_ext = THR_W'(rd_level);
        wr_ext = THR_W'(wr_level);
    end

    // Level comparisons, registered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_af <= 1'b0;
            rd_ne <= 1'b0;
            wr_ae <= 1'b0;
            wr_nf <= 1'b0;
        end else begin
            rd_af <= (rd_ext >= rd_thr);
            rd_ne <= (rd_level != '0);
            wr_ae <= (wr_ext <= wr_thr);
            wr_nf <= (wr_level < DEPTH_V);
        end
    end

endmodule

// File: rtl/fifo_irq_sticky.sv
// Module: fifo_irq_sticky
// N independent sticky flags. A set input wins over a clear in the same cycle.
// Assumes set inputs are already synchronous to clk.
module fifo_irq_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky bit: set has priority over write-one-to-clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/fifo_irq_combine.sv
// Module: fifo_irq_combine
// Masks the flag vector with the enable vector and registers the OR so the
// interrupt output is glitch-free.
module fifo_irq_combine #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic         irq
);

    // Registered OR of enabled requests
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(flags & en);
    end

endmodule

// File: rtl/fifo_irq_ctrl.sv
// Module: fifo_irq_ctrl (top)
// FIFO threshold interrupt controller. Threshold register, level flags,
// sticky error/device flags and a registered combined interrupt.
// Assumes error events and the device line are synchronous to clk, and that
// irq_en comes from a control register held elsewhere.
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int RD_THR_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rd_level,
    input  logic [CNT_W-1:0] wr_level,
    input  logic             dev_irq,
    input  logic             term_err,
    input  logic             bus_tmo,
    input  logic [N_SRC-1:0] irq_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);

    localparam int WR_THR_RST = FIFO_DEPTH - RD_THR_MAX;

    logic [THR_W-1:0]    rd_thr;
    logic [THR_W-1:0]    wr_thr;
    logic [N_STICKY-1:0] sticky_set;
    logic [N_STICKY-1:0] sticky_clr;
    logic [N_STICKY-1:0] sticky_q;
    irq_flags_t          flags;
    logic                unused_wbits;

    // Write-data bits that map to nothing writable
    assign unused_wbits = ^{reg_wdata[31:30], reg_wdata[27:26], reg_wdata[14:10]};

    fifo_irq_thresh #(
        .THR_W      (THR_W),
        .RD_THR_MAX (RD_THR_MAX),
        .WR_THR_RST (WR_THR_RST)
    ) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .rd_thr_in (reg_wdata[RD_THR_LSB +: THR_W]),
        .wr_thr_in (reg_wdata[WR_THR_LSB +: THR_W]),
        .rd_thr    (rd_thr),
        .wr_thr    (wr_thr)
    );

    fifo_irq_level #(
        .CNT_W      (CNT_W),
        .THR_W      (THR_W),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_level (rd_level),
        .wr_level (wr_level),
        .rd_thr   (rd_thr),
        .wr_thr   (wr_thr),
        .rd_af    (flags.rd_af),
        .rd_ne    (flags.rd_ne),
        .wr_ae    (flags.wr_ae),
        .wr_nf    (flags.wr_nf)
    );

    // Sticky sources: index 0 device, 1 terminate, 2 timeout
    always_comb begin
        sticky_set = {bus_tmo, term_err, dev_irq};
        sticky_clr = {3{reg_wr}} & {reg_wdata[BIT_TMO], reg_wdata[BIT_TERM], reg_wdata[BIT_DEV]};
    end

    fifo_irq_sticky #(
        .N (N_STICKY)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sticky_set),
        .clr   (sticky_clr),
        .q     (sticky_q)
    );

    assign flags.dev  = sticky_q[0];
    assign flags.term = sticky_q[1];
    assign flags.tmo  = sticky_q[2];

    fifo_irq_combine #(
        .N (N_SRC)
    ) u_combine (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flags),
        .en    (irq_en),
        .irq   (irq)
    );

    // Assemble the read view of the threshold/status register
    always_comb begin
        reg_rdata                           = '0;
        reg_rdata[RD_THR_LSB +: THR_W]      = rd_thr;
        reg_rdata[WR_THR_LSB +: THR_W]      = wr_thr;
        reg_rdata[BIT_RD_AF]                = flags.rd_af;
        reg_rdata[BIT_RD_NE]                = flags.rd_ne;
        reg_rdata[BIT_WR_AE]                = flags.wr_ae;
        reg_rdata[BIT_WR_NF]                = flags.wr_nf;
        reg_rdata[BIT_DEV]                  = flags.dev;
        reg_rdata[BIT_TERM]                 = flags.term;
        reg_rdata[BIT_TMO]                  = flags.tmo;
    end

endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
// Module: fifo_irq_ctrl_chk
// Port-level property checker for fifo_irq_ctrl, attached by bind below.
module fifo_irq_ctrl_chk
    import fifo_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = 6,
    parameter int RD_THR_MAX = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rd_level,
    input logic [CNT_W-1:0] wr_level,
    input logic             dev_irq,
    input logic             term_err,
    input logic             bus_tmo,
    input logic [N_SRC-1:0] irq_en,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             irq
);

    logic [N_SRC-1:0] rd_flags;

    // Flag vector as seen at the register port, in enable order
    assign rd_flags = {reg_rdata[BIT_TMO], reg_rdata[BIT_TERM], reg_rdata[BIT_DEV],
                       reg_rdata[BIT_WR_NF], reg_rdata[BIT_WR_AE],
                       reg_rdata[BIT_RD_NE], reg_rdata[BIT_RD_AF]};

    p_rd_thr_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[THR_W-1:0] <= THR_W'(RD_THR_MAX));

    p_rd_ne_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_level != '0) |=> reg_rdata[BIT_RD_NE]);

    p_rd_ne_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_level == '0) |=> !reg_rdata[BIT_RD_NE]);

    p_wr_nf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_level < CNT_W'(FIFO_DEPTH)) |=> reg_rdata[BIT_WR_NF]);

    p_term_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        term_err |=> reg_rdata[BIT_TERM]);

    p_tmo_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tmo |=> reg_rdata[BIT_TMO]);

    p_dev_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[BIT_DEV] && !(reg_wr && reg_wdata[BIT_DEV])) |=> reg_rdata[BIT_DEV]);

    p_irq_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(rd_flags & irq_en)));

    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:30] == 2'b00) && (reg_rdata[27:26] == 2'b00) && !reg_rdata[14]);

endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .RD_THR_MAX (RD_THR_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_level  (rd_level),
    .wr_level  (wr_level),
    .dev_irq   (dev_irq),
    .term_err  (term_err),
    .bus_tmo   (bus_tmo),
    .irq_en    (irq_en),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
);

// File: tb/fifo_irq_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for fifo_irq_ctrl: one task per scenario.
// Inputs change just after a falling edge; outputs are checked at falling edges.
module fifo_irq_ctrl_tb;

    localparam int CNT_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [CNT_W-1:0] rd_level = '0;
    logic [CNT_W-1:0] wr_level = '0;
    logic        dev_irq = 1'b0;
    logic        term_err = 1'b0;
    logic        bus_tmo = 1'b0;
    logic [6:0]  irq_en = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fifo_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_level  (rd_level),
        .wr_level  (wr_level),
        .dev_irq   (dev_irq),
        .term_err  (term_err),
        .bus_tmo   (bus_tmo),
        .irq_en    (irq_en),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Compare one value and count the result
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] thr(input int r, input int w);
        return (32'(w) << 16) | 32'(r);
    endfunction

    // Single-cycle register write; returns at the falling edge after the write edge
    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 reset value", reg_rdata, 32'h0018_0008);
        chk("R1 reset irq", {31'b0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_thresh;
        wr_reg(thr(5, 20));
        chk("R2 read threshold", {22'b0, reg_rdata[9:0]}, 32'd5);
        chk("R2 write threshold", {22'b0, reg_rdata[25:16]}, 32'd20);
    endtask

    task automatic t_clamp;
        wr_reg(thr(300, 20));
        chk("R3 clamp above max", {22'b0, reg_rdata[9:0]}, 32'd8);
        wr_reg(thr(8, 20));
        chk("R3 max kept", {22'b0, reg_rdata[9:0]}, 32'd8);
        wr_reg(thr(5, 20));
    endtask

    task automatic t_rd_levels;
        @(negedge clk); rd_level = 6'd4;
        @(negedge clk);
        chk("R4 below threshold", {31'b0, reg_rdata[10]}, 32'd0);
        chk("R5 nonzero", {31'b0, reg_rdata[11]}, 32'd1);
        rd_level = 6'd5;
        @(negedge clk);
        chk("R4 at threshold", {31'b0, reg_rdata[10]}, 32'd1);
        rd_level = 6'd32;
        @(negedge clk);
        chk("R4 full", {31'b0, reg_rdata[10]}, 32'd1);
        rd_level = 6'd0;
        @(negedge clk);
        chk("R5 empty", {31'b0, reg_rdata[11]}, 32'd0);
        chk("R4 empty", {31'b0, reg_rdata[10]}, 32'd0);
    endtask

    task automatic t_wr_levels;
        @(negedge clk); wr_level = 6'd20;
        @(negedge clk);
        chk("R6 at threshold", {31'b0, reg_rdata[12]}, 32'd1);
        wr_level = 6'd21;
        @(negedge clk);
        chk("R6 above threshold", {31'b0, reg_rdata[12]}, 32'd0);
        chk("R7 room left", {31'b0, reg_rdata[13]}, 32'd1);
        wr_level = 6'd31;
        @(negedge clk);
        chk("R7 one slot", {31'b0, reg_rdata[13]}, 32'd1);
        wr_level = 6'd32;
        @(negedge clk);
        chk("R7 full", {31'b0, reg_rdata[13]}, 32'd0);
    endtask

    task automatic t_sticky;
        @(negedge clk); term_err = 1'b1;
        @(negedge clk); term_err = 1'b0;
        chk("R8 term set", {31'b0, reg_rdata[28]}, 32'd1);
        @(negedge clk);
        chk("R8 term held", {31'b0, reg_rdata[28]}, 32'd1);
        wr_reg(thr(5, 20));
        chk("R8 write zero keeps", {31'b0, reg_rdata[28]}, 32'd1);
        wr_reg(thr(5, 20) | (32'd1 << 28));
        chk("R8 write one clears", {31'b0, reg_rdata[28]}, 32'd0);
        dev_irq = 1'b1;
        @(negedge clk);
        chk("R8 dev set", {31'b0, reg_rdata[15]}, 32'd1);
        wr_reg(thr(5, 20) | (32'd1 << 15));
        chk("R8 dev line high wins", {31'b0, reg_rdata[15]}, 32'd1);
        dev_irq = 1'b0;
        wr_reg(thr(5, 20) | (32'd1 << 15));
        chk("R8 dev cleared", {31'b0, reg_rdata[15]}, 32'd0);
        @(negedge clk);
        bus_tmo = 1'b1;
        reg_wr = 1'b1;
        reg_wdata = thr(5, 20) | (32'd1 << 29);
        @(negedge clk);
        bus_tmo = 1'b0;
        reg_wr = 1'b0;
        reg_wdata = '0;
        chk("R8 set beats clear", {31'b0, reg_rdata[29]}, 32'd1);
        wr_reg(thr(5, 20) | (32'd1 << 29));
        chk("R8 tmo cleared", {31'b0, reg_rdata[29]}, 32'd0);
    endtask

    task automatic t_irq;
        // rd_level 0, wr_level 32: all flags clear
        @(negedge clk); irq_en = 7'b000_0010;
        @(negedge clk);
        chk("R9 no enabled flag", {31'b0, irq}, 32'd0);
        rd_level = 6'd1;
        @(negedge clk);
        chk("R9 one edge after level", {31'b0, irq}, 32'd0);
        @(negedge clk);
        chk("R9 two edges after level", {31'b0, irq}, 32'd1);
        irq_en = 7'b000_0000;
        @(negedge clk);
        chk("R9 masked", {31'b0, irq}, 32'd0);
        irq_en = 7'b010_0000;
        term_err = 1'b1;
        @(negedge clk); term_err = 1'b0;
        @(negedge clk);
        chk("R9 term enabled", {31'b0, irq}, 32'd1);
        wr_reg(thr(5, 20) | (32'd1 << 28));
        @(negedge clk);
        chk("R9 after clear", {31'b0, irq}, 32'd0);
        irq_en = '0;
        rd_level = '0;
    endtask

    task automatic t_rsvd;
        wr_reg(thr(5, 20) | 32'hCC00_4000);
        chk("R10 reserved zero", reg_rdata & 32'hCC00_4000, 32'd0);
        chk("R10 thresholds intact", reg_rdata & 32'h03FF_03FF, thr(5, 20));
    endtask

    initial begin
        t_reset;
        t_thresh;
        t_clamp;
        t_rd_levels;
        t_wr_levels;
        t_sticky;
        t_irq;
        t_rsvd;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule